// File: doc/BRIEF.md
# Fractional-Rate Full-Duplex UART

This block is an asynchronous serial transmitter and receiver that share one bit-rate setting. The bit time is counted in thirds of a system clock cycle, so a 9-bit rate value N gives a bit period of (N+1)*16/3 clocks. The shortest period is 16/3 clocks and the longest is 8192/3 clocks. A phase accumulator keeps the fractional remainder from one bit to the next, so the error in bit edges does not build up over a frame or over a run of frames.

Each frame is a low start bit, then 7, 8 or 9 data bits sent least significant bit first, then a high stop bit. There is no parity. Words for the transmitter enter through a valid/ready handshake into one holding register. Received words leave as a one-cycle valid pulse with a framing-error flag. When the continuous setting is on and a word is waiting, the transmitter puts two stop bits between frames. With the setting off it puts one. Transmitter and receiver run on separate timing, so the block can send and receive at the same time.

Top module: `frac_uart`

## Requirements
- R1: The rate input N (0 to 511) sets the bit period to (N+1)*16/3 clocks. Bit k of a frame begins ceil(k*16*(N+1)/3) clocks after the frame's start edge, and the fractional phase carries over into any frame that follows without idle time.
- R2: The length select gives 7 data bits for code 0, 8 for code 1 and 9 for code 2. Code 3 gives 8 bits.
- R3: A transmitted frame is one low start bit, then the data bits least significant first, then a high stop bit. No parity bit is sent.
- R4: With continuous mode off and a word waiting, the next start bit follows exactly one stop bit.
- R5: With continuous mode on and a word waiting, the next start bit follows exactly two stop bits.
- R6: After reset and whenever the transmitter is idle, the TX line is high. After reset the transmitter is ready and no receive valid is raised.
- R7: The transmitter holds one waiting word. Ready is low while that register is full. A word is taken in on a cycle where valid and ready are both high.
- R8: The receiver starts on a falling edge of the idle-high line and checks the line again at mid start bit. A low pulse shorter than half a bit produces no word.
- R9: The receiver samples each data bit at its centre and presents the word right-aligned, with a valid pulse one cycle long.
- R10: The framing-error flag is 1 with the valid pulse when the stop bit is sampled low, and 0 when it is sampled high.
- R11: A frame can be sent and another received at the same time without either being disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgRate | input | 9 | Rate value N; bit period (N+1)*16/3 clocks |
| cfgLen | input | 2 | Data length select (0:7, 1:8, 2:9, 3:8 bits) |
| cfgCont | input | 1 | Continuous mode: two stop bits between queued frames |
| txData | input | 9 | Word to send, right-aligned |
| txValid | input | 1 | Transmit word offered |
| txReady | output | 1 | Holding register empty |
| rxData | output | 9 | Received word, right-aligned |
| rxValid | output | 1 | One-cycle pulse when a word is received |
| rxFrameErr | output | 1 | Stop bit sampled low; valid with rxValid |
| txPin | output | 1 | Serial transmit line |
| rxPin | input | 1 | Serial receive line |

## Verification
Two events can fall in the same cycle: the transmitter taking its next word and starting a frame, and the receiver finishing a word with its valid pulse and mid-stop sample. This is provoked by looping the TX line back to the receiver during queued bursts, and by driving a separate frame into the receiver while the transmitter is sending. The bench judges the result by decoding the TX line at computed bit centres, comparing each frame's start cycle with the exact ceiling of its fractional bit positions, and checking every received word and error flag against the word that was sent.

// File: rtl/frac_uart_pkg.sv
`timescale 1ns/1ps
package frac_uart_pkg;

  typedef enum logic [2:0] {
    TX_IDLE, TX_START, TX_DATA, TX_STOP1, TX_STOP2
  } txState_t;

  typedef enum logic [1:0] {
    RX_IDLE, RX_START, RX_DATA, RX_STOP
  } rxState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic txLoad;    // move holding word to shifter, drive start bit
    logic txShift;   // drive next data bit
    logic txStop;    // drive stop level
    logic rxSample;  // capture one data bit
    logic rxDone;    // capture stop bit, publish word
  } strobe_t;

  function automatic logic [3:0] frameBits(input logic [1:0] sel);
    case (sel)
      2'd0:    return 4'd7;
      2'd2:    return 4'd9;
      default: return 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/frac_uart_baud.sv
`timescale 1ns/1ps
module frac_uart_baud #(
  parameter int RATE_W = 9,
  parameter int STEP   = 3,
  parameter int SUB    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clr,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);
  localparam int ACC_W = RATE_W + $clog2(SUB) + 2;

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] sum;
  logic [ACC_W-1:0] lim;
  logic [ACC_W-1:0] wrapped;

  always_comb begin
    lim     = (ACC_W'(rate) + ACC_W'(1)) * ACC_W'(SUB);
    sum     = acc + ACC_W'(STEP);
    wrapped = sum - lim;
    tick    = !clr && (sum >= lim);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      acc <= '0;
    else if (clr)   acc <= '0;
    else if (tick)  acc <= (wrapped >= lim) ? '0 : wrapped;
    else            acc <= sum;
  end

  // R1
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tick && $stable(rate)) |=> (!tick || !$stable(rate)));

endmodule

// File: rtl/frac_uart_ctrl.sv
`timescale 1ns/1ps
module frac_uart_ctrl
  import frac_uart_pkg::*;
#(
  parameter int RATE_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [RATE_W-1:0] rate,
  input  logic [1:0]        lenSel,
  input  logic              contMode,
  input  logic              holdFull,
  input  logic              rxLine,
  output strobe_t           strb,
  output logic              txIdle
);
  txState_t txState, txNext;
  rxState_t rxState, rxNext;
  logic [3:0] txCnt, txCntNext;
  logic [3:0] rxCnt, rxCntNext;
  logic       rxPhase, rxPhaseNext;
  logic       lastLine;
  logic       txClr, rxClr, txTick, rxHalf;
  logic       txLoad, txShift, txStop, rxSample, rxDone;
  logic [3:0] bits;

  assign bits = frameBits(lenSel);

  // full-bit timing for the transmitter, half-bit timing for the receiver
  frac_uart_baud #(.RATE_W(RATE_W), .STEP(3), .SUB(16)) u_txBaud (
    .clk(clk), .rstN(rstN), .clr(txClr), .rate(rate), .tick(txTick));
  frac_uart_baud #(.RATE_W(RATE_W), .STEP(6), .SUB(16)) u_rxBaud (
    .clk(clk), .rstN(rstN), .clr(rxClr), .rate(rate), .tick(rxHalf));

  always_comb begin
    txNext    = txState;
    txCntNext = txCnt;
    txClr     = 1'b0;
    txLoad    = 1'b0;
    txShift   = 1'b0;
    txStop    = 1'b0;
    case (txState)
      TX_IDLE: if (holdFull) begin
        txLoad = 1'b1;
        txClr  = 1'b1;
        txNext = TX_START;
      end
      TX_START: if (txTick) begin
        txShift   = 1'b1;
        txCntNext = '0;
        txNext    = TX_DATA;
      end
      TX_DATA: if (txTick) begin
        if (txCnt == bits - 4'd1) begin
          txStop = 1'b1;
          txNext = TX_STOP1;
        end else begin
          txShift   = 1'b1;
          txCntNext = txCnt + 4'd1;
        end
      end
      TX_STOP1: if (txTick) begin
        if (!holdFull)     txNext = TX_IDLE;
        else if (contMode) txNext = TX_STOP2;
        else begin
          txLoad = 1'b1;
          txNext = TX_START;
        end
      end
      TX_STOP2: if (txTick) begin
        if (holdFull) begin
          txLoad = 1'b1;
          txNext = TX_START;
        end else txNext = TX_IDLE;
      end
      default: txNext = TX_IDLE;
    endcase
  end

  always_comb begin
    rxNext      = rxState;
    rxCntNext   = rxCnt;
    rxPhaseNext = rxPhase;
    rxClr       = 1'b0;
    rxSample    = 1'b0;
    rxDone      = 1'b0;
    case (rxState)
      RX_IDLE: if (lastLine && !rxLine) begin
        rxClr  = 1'b1;
        rxNext = RX_START;
      end
      RX_START: if (rxHalf) begin
        if (!rxLine) begin
          rxNext      = RX_DATA;
          rxPhaseNext = 1'b0;
          rxCntNext   = '0;
        end else rxNext = RX_IDLE;
      end
      RX_DATA: if (rxHalf) begin
        rxPhaseNext = !rxPhase;
        if (rxPhase) begin
          rxSample = 1'b1;
          if (rxCnt == bits - 4'd1) begin
            rxNext      = RX_STOP;
            rxPhaseNext = 1'b0;
          end else rxCntNext = rxCnt + 4'd1;
        end
      end
      RX_STOP: if (rxHalf) begin
        rxPhaseNext = !rxPhase;
        if (rxPhase) begin
          rxDone = 1'b1;
          rxNext = RX_IDLE;
        end
      end
      default: rxNext = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txState  <= TX_IDLE;
      txCnt    <= '0;
      rxState  <= RX_IDLE;
      rxCnt    <= '0;
      rxPhase  <= 1'b0;
      lastLine <= 1'b1;
    end else begin
      txState  <= txNext;
      txCnt    <= txCntNext;
      rxState  <= rxNext;
      rxCnt    <= rxCntNext;
      rxPhase  <= rxPhaseNext;
      lastLine <= rxLine;
    end
  end

  assign strb   = '{txLoad: txLoad, txShift: txShift, txStop: txStop,
                    rxSample: rxSample, rxDone: rxDone};
  assign txIdle = (txState == TX_IDLE);

  // R8
  start_recheck_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxState == RX_START && rxHalf && rxLine) |=> !strb.rxDone && rxState == RX_IDLE);

endmodule

// File: rtl/frac_uart_dp.sv
`timescale 1ns/1ps
module frac_uart_dp
  import frac_uart_pkg::*;
#(
  parameter int DATA_W      = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        lenSel,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] txData,
  input  logic              txValid,
  input  logic              rxPin,
  output logic              holdFull,
  output logic              txReady,
  output logic              txLine,
  output logic              rxLine,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              rxFrameErr
);
  logic [DATA_W-1:0] holdReg;
  logic [DATA_W-1:0] txShiftReg;
  logic [DATA_W-1:0] rxShiftReg;
  logic [3:0]        alignShift;
  logic              accept;

  assign txReady    = !holdFull;
  assign accept     = txValid && !holdFull;
  assign alignShift = 4'(DATA_W) - frameBits(lenSel);

  // input synchronizer, depth chosen by parameter
  generate
    if (SYNC_STAGES > 1) begin : g_sync
      logic [SYNC_STAGES-1:0] syncQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], rxPin};
      end
      assign rxLine = syncQ[SYNC_STAGES-1];
    end else begin : g_sync1
      logic syncQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= 1'b1;
        else       syncQ <= rxPin;
      end
      assign rxLine = syncQ;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg    <= '0;
      holdFull   <= 1'b0;
      txShiftReg <= '0;
      txLine     <= 1'b1;
    end else begin
      if (strb.txLoad) begin
        txShiftReg <= holdReg;
        holdFull   <= 1'b0;
        txLine     <= 1'b0;
      end else begin
        if (accept) begin
          holdReg  <= txData;
          holdFull <= 1'b1;
        end
        if (strb.txShift) begin
          txLine     <= txShiftReg[0];
          txShiftReg <= txShiftReg >> 1;
        end else if (strb.txStop) begin
          txLine <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShiftReg <= '0;
      rxData     <= '0;
      rxValid    <= 1'b0;
      rxFrameErr <= 1'b0;
    end else begin
      rxValid <= strb.rxDone;
      if (strb.rxSample) rxShiftReg <= {rxLine, rxShiftReg[DATA_W-1:1]};
      if (strb.rxDone) begin
        rxData     <= rxShiftReg >> alignShift;
        rxFrameErr <= !rxLine;
      end
    end
  end

  // R3
  start_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.txLoad |=> !txLine);

  // R7
  hold_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> !txReady && holdReg == $past(txData));

  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

endmodule

// File: rtl/frac_uart.sv
`timescale 1ns/1ps
module frac_uart
  import frac_uart_pkg::*;
#(
  parameter int RATE_W      = 9,
  parameter int DATA_W      = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [RATE_W-1:0] cfgRate,
  input  logic [1:0]        cfgLen,
  input  logic              cfgCont,
  input  logic [DATA_W-1:0] txData,
  input  logic              txValid,
  output logic              txReady,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              rxFrameErr,
  output logic              txPin,
  input  logic              rxPin
);
  strobe_t strb;
  logic    holdFull;
  logic    rxLine;
  logic    txIdle;

  frac_uart_ctrl #(.RATE_W(RATE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .rate(cfgRate), .lenSel(cfgLen),
    .contMode(cfgCont), .holdFull(holdFull), .rxLine(rxLine),
    .strb(strb), .txIdle(txIdle));

  frac_uart_dp #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .lenSel(cfgLen), .strb(strb),
    .txData(txData), .txValid(txValid), .rxPin(rxPin),
    .holdFull(holdFull), .txReady(txReady), .txLine(txPin),
    .rxLine(rxLine), .rxData(rxData), .rxValid(rxValid),
    .rxFrameErr(rxFrameErr));

  // R6
  idle_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    txIdle |-> txPin);

endmodule

// File: tb/frac_uart_tb.sv
`timescale 1ns/1ps
module frac_uart_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [8:0] cfgRate = '0;
  logic [1:0] cfgLen = 2'd1;
  logic       cfgCont = 1'b0;
  logic [8:0] txData = '0;
  logic       txValid = 1'b0;
  logic       txReady;
  logic [8:0] rxData;
  logic       rxValid;
  logic       rxFrameErr;
  logic       txPin;
  logic       rxPin;
  logic       benchRx = 1'b1;
  logic       loopSel = 1'b0;

  assign rxPin = loopSel ? txPin : benchRx;

  frac_uart u_dut (
    .clk(clk), .rstN(rstN), .cfgRate(cfgRate), .cfgLen(cfgLen),
    .cfgCont(cfgCont), .txData(txData), .txValid(txValid),
    .txReady(txReady), .rxData(rxData), .rxValid(rxValid),
    .rxFrameErr(rxFrameErr), .txPin(txPin), .rxPin(rxPin));

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int bitsOf(input logic [1:0] sel);
    return (sel == 2'd0) ? 7 : (sel == 2'd2) ? 9 : 8;
  endfunction

  // TX line decoder: samples at computed bit centres
  int monCount = 0;
  int monWord[64];
  int monStart[64];
  int monBad[64];
  initial begin
    logic prev;
    int t0, b, lb, w, bad;
    prev = 1'b1;
    forever begin
      @(negedge clk);
      if (!rstN) prev = 1'b1;
      else if (prev && !txPin) begin
        t0 = cyc; b = bitsOf(cfgLen); lb = 16 * (int'(cfgRate) + 1);
        w = 0; bad = 0;
        for (int k = 0; k <= b + 1; k++) begin
          while (cyc < t0 + ((2 * k + 1) * lb) / 6) @(negedge clk);
          if (k == 0)      bad += int'(txPin);
          else if (k <= b) w |= int'(txPin) << (k - 1);
          else             bad += int'(!txPin);
        end
        monWord[monCount % 64]  = w;
        monStart[monCount % 64] = t0;
        monBad[monCount % 64]   = bad;
        monCount++;
        prev = 1'b1;
      end else prev = txPin;
    end
  end

  // RX output collector
  int rxCount = 0;
  int rxWords[64];
  int rxErrs[64];
  always @(negedge clk) begin
    if (rstN && rxValid) begin
      rxWords[rxCount % 64] = int'(rxData);
      rxErrs[rxCount % 64]  = int'(rxFrameErr);
      rxCount++;
    end
  end

  task automatic sendTx(input int w);
    @(negedge clk);
    txData  = 9'(w);
    txValid = 1'b1;
    while (!txReady) @(negedge clk);
    @(negedge clk);
    txValid = 1'b0;
    check(txReady == 1'b0, "R7 ready low after accept", int'(txReady), 0);
  endtask

  task automatic driveRx(input int w, input int b, input int lb, input bit stopLvl);
    int c0;
    @(negedge clk);
    c0 = cyc;
    for (int k = 0; k <= b + 1; k++) begin
      while (cyc < c0 + (k * lb + 2) / 3) @(negedge clk);
      if (k == 0)      benchRx = 1'b0;
      else if (k <= b) benchRx = 1'((w >> (k - 1)) & 1);
      else             benchRx = stopLvl;
    end
    while (cyc < c0 + ((b + 2) * lb + 2) / 3) @(negedge clk);
    benchRx = 1'b1;
    repeat (lb) @(negedge clk);
  endtask

  task automatic waitCounts(input int mTarget, input int rTarget);
    int t;
    t = 0;
    while ((monCount < mTarget || rxCount < rTarget) && t < 100000) begin
      @(negedge clk);
      t++;
    end
  endtask

  // queued frames through loopback; checks start spacing and words
  task automatic runBurst(input int rate, input int len, input bit cont, input int n);
    int m0, r0, b, lb, s, mask, w, expGap;
    cfgRate = 9'(rate); cfgLen = 2'(len); cfgCont = cont; loopSel = 1'b1;
    b = bitsOf(cfgLen); lb = 16 * (rate + 1); s = cont ? 3 : 2;
    mask = (1 << b) - 1;
    m0 = monCount; r0 = rxCount;
    for (int i = 0; i < n; i++) sendTx((9'h0A5 + i * 9'h067) & 9'h1FF);
    waitCounts(m0 + n, r0 + n);
    for (int i = 0; i < n; i++) begin
      w = ((9'h0A5 + i * 9'h067) & 9'h1FF) & mask;
      check(monWord[(m0 + i) % 64] == w, "R3 burst tx word", monWord[(m0 + i) % 64], w);
      check(rxWords[(r0 + i) % 64] == w, "R11 burst loop rx word", rxWords[(r0 + i) % 64], w);
      if (i > 0) begin
        expGap = (i * (b + s) * lb + 2) / 3;
        if (cont) check(monStart[(m0 + i) % 64] - monStart[m0 % 64] == expGap,
                        "R5 two-stop spacing", monStart[(m0 + i) % 64] - monStart[m0 % 64], expGap);
        else      check(monStart[(m0 + i) % 64] - monStart[m0 % 64] == expGap,
                        "R4 R1 one-stop spacing", monStart[(m0 + i) % 64] - monStart[m0 % 64], expGap);
      end
    end
    repeat (lb) @(negedge clk);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int m0, r0, b, lb, w, mask, rate;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R6 reset state
    check(txPin == 1'b1, "R6 tx idle high", int'(txPin), 1);
    check(txReady == 1'b1, "R6 ready after reset", int'(txReady), 1);
    check(rxValid == 1'b0, "R6 no rx valid after reset", int'(rxValid), 0);

    // sweep rates, lengths and words through loopback (R1 R2 R3 R9 R10)
    loopSel = 1'b1;
    for (int ri = 0; ri < 3; ri++) begin
      for (int li = 0; li < 4; li++) begin
        for (int wi = 0; wi < 3; wi++) begin
          rate = (ri == 0) ? 0 : (ri == 1) ? 1 : 4;
          cfgRate = 9'(rate); cfgLen = 2'(li); cfgCont = 1'b0;
          b = bitsOf(cfgLen); lb = 16 * (rate + 1); mask = (1 << b) - 1;
          w = (wi == 0) ? 9'h055 : (wi == 1) ? 9'h1FF : ((rate * 97 + li * 41 + 173) & 9'h1FF);
          m0 = monCount; r0 = rxCount;
          sendTx(w);
          waitCounts(m0 + 1, r0 + 1);
          check(monWord[m0 % 64] == (w & mask), "R2 R3 tx word by length", monWord[m0 % 64], w & mask);
          check(monBad[m0 % 64] == 0, "R3 start low stop high", monBad[m0 % 64], 0);
          check(rxWords[r0 % 64] == (w & mask), "R9 R1 rx word", rxWords[r0 % 64], w & mask);
          check(rxErrs[r0 % 64] == 0, "R10 no framing error", rxErrs[r0 % 64], 0);
          repeat (lb) @(negedge clk);
          check(txPin == 1'b1, "R6 idle high after frame", int'(txPin), 1);
        end
      end
    end

    // spacing of queued frames
    runBurst(0, 1, 1'b0, 3);
    runBurst(2, 2, 1'b0, 3);
    runBurst(0, 0, 1'b1, 3);
    runBurst(3, 1, 1'b1, 3);
    runBurst(511, 1, 1'b0, 2);

    // simultaneous send and receive
    loopSel = 1'b0; cfgRate = 9'd2; cfgLen = 2'd2; cfgCont = 1'b0;
    m0 = monCount; r0 = rxCount;
    fork
      sendTx(9'h1A5);
      driveRx(9'h0C3, 9, 48, 1'b1);
    join
    waitCounts(m0 + 1, r0 + 1);
    check(monWord[m0 % 64] == 9'h1A5, "R11 tx during rx", monWord[m0 % 64], 9'h1A5);
    check(rxWords[r0 % 64] == 9'h0C3, "R11 rx during tx", rxWords[r0 % 64], 9'h0C3);

    // framing error, then clean frame
    cfgLen = 2'd1;
    r0 = rxCount;
    driveRx(8'h3C, 8, 48, 1'b0);
    waitCounts(monCount, r0 + 1);
    check(rxErrs[r0 % 64] == 1, "R10 stop low flags error", rxErrs[r0 % 64], 1);
    check(rxWords[r0 % 64] == 8'h3C, "R10 data kept with error", rxWords[r0 % 64], 8'h3C);
    r0 = rxCount;
    driveRx(8'h81, 8, 48, 1'b1);
    waitCounts(monCount, r0 + 1);
    check(rxErrs[r0 % 64] == 0, "R10 error clears", rxErrs[r0 % 64], 0);
    check(rxWords[r0 % 64] == 8'h81, "R9 word after error", rxWords[r0 % 64], 8'h81);

    // short low glitch is rejected
    r0 = rxCount;
    @(negedge clk); benchRx = 1'b0;
    @(negedge clk); benchRx = 1'b1;
    repeat (400) @(negedge clk);
    check(rxCount == r0, "R8 glitch gives no word", rxCount - r0, 0);
    driveRx(8'h5A, 8, 48, 1'b1);
    waitCounts(monCount, r0 + 1);
    check(rxCount == r0 + 1 && rxWords[r0 % 64] == 8'h5A, "R8 receive after glitch",
          rxWords[r0 % 64], 8'h5A);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule